// File: doc/BRIEF.md
# Timed Cell Balance Output Controller

This block drives six cell-balance enable outputs, one for each external balancing switch. The host decides which cells to balance and writes a one-bit-per-output pattern into a control register. The block applies no algorithm of its own. It gates the outputs and enforces a maximum balancing time, which the host sets in whole minutes in a second register.

A one-second tick input feeds a seconds counter. Every sixtieth counted tick advances a minute counter. Time is counted only while at least one output is enabled. When the elapsed minutes reach the programmed limit, the block clears the control pattern, forces every output low and sets a sticky timeout flag. The flag stays set until the host clears it.

The host reaches both registers through a plain register port. Writes take effect at a clock edge and reads are combinational.

Top module: `balance_gate_ctrl`

## Requirements
- R1: A synchronous reset clears the control pattern, the minute limit, the timeout flag and both counters, so every output is low and both registers read 0.
- R2: A write to address 0x32 stores wdata[5:0] as the control pattern. While the minute limit is nonzero, output bal_en[i] equals pattern bit i from the next clock.
- R3: While the minute limit is 0, all outputs stay low whatever the pattern. The pattern is retained, and it appears on the outputs once a nonzero limit is written.
- R4: A write of a nonzero pattern to 0x32 restarts the elapsed time from zero. A write of zero turns all outputs off.
- R5: After the 60×L-th counted tick, with limit L between 1 and 63, the outputs stay on for one more cycle. At the following clock edge the pattern clears and all outputs go low.
- R6: Timer register (0x33) bit 7 is a timeout flag. It is set by a timeout and holds until a write to 0x33 with bit 7 = 1 clears it. A timeout in the same cycle as the clearing write wins.
- R7: Timer register bit 6 reads 1 exactly when at least one output is on.
- R8: A read of 0x32 returns {2'b00, bal_en}. A read of 0x33 returns {timeout flag, active, limit[5:0]}. Any other address reads 0. A write to 0x33 stores wdata[5:0] as the limit.
- R9: If the limit is written to a value that is nonzero and at most the minutes already elapsed, the outputs go low one cycle after that write takes effect.
- R10: A control write in the same cycle as a pending timeout takes priority. The new pattern is stored, time restarts, and the timeout flag is not set.
- R11: Ticks that arrive while no output is on (pattern 0 or limit 0) do not advance the elapsed time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data for reg_addr |
| sec_tick | input | 1 | One-cycle pulse marking one second |
| bal_en | output | 6 | Balance switch enables |

## Verification
Assertions check the following on every cycle:
- the seconds counter stays in range;
- a nonzero control write zeroes both counters;
- the counters freeze while balancing is inactive;
- a timeout clears the pattern and sets the flag;
- the flag holds until it is cleared;
- a zero limit keeps the outputs low;
- an output is never on unless its pattern bit is set.

Only the bench's scenarios can show the exact tick count at which a timeout happens. The same goes for the one-cycle delay after the final tick, lowering the limit below the elapsed time, and the priority of a control write over a pending timeout. The bench checks these against an elapsed-tick model.

// File: rtl/bal_pkg.sv
package bal_pkg;

  localparam int BAL_OUTPUTS   = 6;
  localparam int BAL_LIMIT_W   = 6;
  localparam int BAL_DATA_W    = 8;
  localparam int BAL_ADDR_W    = 8;
  localparam int BAL_TICKS_MIN = 60;

  // Width of a counter that holds values 0 .. n-1 (at least one bit).
  function automatic int cnt_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // True when the seconds count sits on the last tick of a minute.
  function automatic logic is_last_tick(input int sec, input int per_min);
    return sec == per_min - 1;
  endfunction

  // True once elapsed minutes have reached the programmed limit.
  function automatic logic limit_reached(input int mins, input int lim);
    return mins >= lim;
  endfunction

endpackage

// File: rtl/bal_minute_timer.sv
module bal_minute_timer #(
  parameter int LIM_W         = bal_pkg::BAL_LIMIT_W,
  parameter int TICKS_PER_MIN = bal_pkg::BAL_TICKS_MIN,
  parameter int SEC_W         = bal_pkg::cnt_width(TICKS_PER_MIN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active,
  input  logic             restart,
  input  logic             tick,
  input  logic [LIM_W-1:0] limit,
  output logic             expire,
  output logic [SEC_W-1:0] sec_cnt,
  output logic [LIM_W-1:0] min_cnt
);

  logic sec_wrap;
  logic advance;

  assign sec_wrap = bal_pkg::is_last_tick(int'(sec_cnt), TICKS_PER_MIN);
  assign expire   = active && bal_pkg::limit_reached(int'(min_cnt), int'(limit));
  assign advance  = active && !expire && tick;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      sec_cnt <= '0;
      min_cnt <= '0;
    end else if (advance) begin
      if (sec_wrap) begin
        sec_cnt <= '0;
        min_cnt <= min_cnt + 1'b1;
      end else begin
        sec_cnt <= sec_cnt + 1'b1;
      end
    end
  end

  AST_SEC_RANGE: assert property (@(posedge clk) disable iff (rst)
    int'(sec_cnt) < TICKS_PER_MIN);                                   // R5
  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (rst)
    restart |=> (sec_cnt == '0 && min_cnt == '0));                    // R4
  AST_IDLE_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (!active && !restart) |=> ($stable(sec_cnt) && $stable(min_cnt))); // R11

endmodule

// File: rtl/bal_reg_block.sv
module bal_reg_block #(
  parameter int N_OUT      = bal_pkg::BAL_OUTPUTS,
  parameter int LIM_W      = bal_pkg::BAL_LIMIT_W,
  parameter int DW         = bal_pkg::BAL_DATA_W,
  parameter int AW         = bal_pkg::BAL_ADDR_W,
  parameter int CTRL_ADDR  = 'h32,
  parameter int TIMER_ADDR = 'h33
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  input  logic             expire,
  input  logic             active,
  input  logic [N_OUT-1:0] bal_en,
  output logic [N_OUT-1:0] ctrl_q,
  output logic [LIM_W-1:0] limit_q,
  output logic             sticky_q,
  output logic             restart,
  output logic [DW-1:0]    rdata
);

  localparam int ACT_BIT = DW - 2;
  localparam int STK_BIT = DW - 1;

  logic ctrl_wr;
  logic timer_wr;
  logic timeout_evt;
  logic sticky_clr;
  wire  unused_wbits = ^wdata;

  assign ctrl_wr     = we && (addr == AW'(CTRL_ADDR));
  assign timer_wr    = we && (addr == AW'(TIMER_ADDR));
  assign restart     = ctrl_wr && (wdata[N_OUT-1:0] != '0);
  assign timeout_evt = expire && !ctrl_wr;
  assign sticky_clr  = timer_wr && wdata[STK_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (ctrl_wr) begin
      ctrl_q <= wdata[N_OUT-1:0];
    end else if (timeout_evt) begin
      ctrl_q <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      limit_q <= '0;
    end else if (timer_wr) begin
      limit_q <= wdata[LIM_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sticky_q <= 1'b0;
    end else if (timeout_evt) begin
      sticky_q <= 1'b1;
    end else if (sticky_clr) begin
      sticky_q <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == AW'(CTRL_ADDR)) begin
      rdata[N_OUT-1:0] = bal_en;
    end else if (addr == AW'(TIMER_ADDR)) begin
      rdata[LIM_W-1:0] = limit_q;
      rdata[ACT_BIT]   = active;
      rdata[STK_BIT]   = sticky_q;
    end
  end

  AST_TIMEOUT_CLEARS: assert property (@(posedge clk) disable iff (rst)
    timeout_evt |=> (ctrl_q == '0));                                  // R5
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
    ctrl_wr |=> (ctrl_q == $past(wdata[N_OUT-1:0])));                 // R10
  AST_STICKY_SET: assert property (@(posedge clk) disable iff (rst)
    timeout_evt |=> sticky_q);                                        // R6
  AST_STICKY_KEEP: assert property (@(posedge clk) disable iff (rst)
    (sticky_q && !sticky_clr) |=> sticky_q);                          // R6

endmodule

// File: rtl/bal_out_gate.sv
module bal_out_gate #(
  parameter int N_OUT = bal_pkg::BAL_OUTPUTS,
  parameter int LIM_W = bal_pkg::BAL_LIMIT_W
) (
  input  logic [N_OUT-1:0] ctrl,
  input  logic [LIM_W-1:0] limit,
  output logic [N_OUT-1:0] bal_en,
  output logic             active
);

  logic limit_nz;
  assign limit_nz = |limit;

  for (genvar i = 0; i < N_OUT; i++) begin : g_gate
    assign bal_en[i] = ctrl[i] & limit_nz;
  end

  assign active = |bal_en;

endmodule

// File: rtl/balance_gate_ctrl.sv
module balance_gate_ctrl #(
  parameter int N_OUT         = bal_pkg::BAL_OUTPUTS,
  parameter int LIM_W         = bal_pkg::BAL_LIMIT_W,
  parameter int DW            = bal_pkg::BAL_DATA_W,
  parameter int AW            = bal_pkg::BAL_ADDR_W,
  parameter int CTRL_ADDR     = 'h32,
  parameter int TIMER_ADDR    = 'h33,
  parameter int TICKS_PER_MIN = bal_pkg::BAL_TICKS_MIN
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_we,
  input  logic [AW-1:0]    reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  input  logic             sec_tick,
  output logic [N_OUT-1:0] bal_en
);

  localparam int SEC_W = bal_pkg::cnt_width(TICKS_PER_MIN);

  logic [N_OUT-1:0] ctrl_q;
  logic [LIM_W-1:0] limit_q;
  logic             sticky_q;
  logic             restart;
  logic             expire;
  logic             active;
  logic [SEC_W-1:0] sec_cnt;
  logic [LIM_W-1:0] min_cnt;

  bal_reg_block #(
    .N_OUT(N_OUT), .LIM_W(LIM_W), .DW(DW), .AW(AW),
    .CTRL_ADDR(CTRL_ADDR), .TIMER_ADDR(TIMER_ADDR)
  ) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .expire(expire), .active(active), .bal_en(bal_en),
    .ctrl_q(ctrl_q), .limit_q(limit_q), .sticky_q(sticky_q),
    .restart(restart), .rdata(reg_rdata)
  );

  bal_minute_timer #(
    .LIM_W(LIM_W), .TICKS_PER_MIN(TICKS_PER_MIN), .SEC_W(SEC_W)
  ) u_timer (
    .clk(clk), .rst(rst), .active(active), .restart(restart), .tick(sec_tick),
    .limit(limit_q), .expire(expire), .sec_cnt(sec_cnt), .min_cnt(min_cnt)
  );

  bal_out_gate #(.N_OUT(N_OUT), .LIM_W(LIM_W)) u_gate (
    .ctrl(ctrl_q), .limit(limit_q), .bal_en(bal_en), .active(active)
  );

  AST_ZERO_LIMIT_OFF: assert property (@(posedge clk) disable iff (rst)
    (limit_q == '0) |-> (bal_en == '0));                              // R3
  AST_OUT_SUBSET: assert property (@(posedge clk) disable iff (rst)
    (bal_en & ~ctrl_q) == '0);                                        // R2
  AST_NO_EXPIRE_IDLE: assert property (@(posedge clk) disable iff (rst)
    !active |-> !expire);                                             // R11
  AST_STICKY_RESET: assert property (@(posedge clk)
    $fell(rst) |-> (!sticky_q && bal_en == '0 && sec_cnt == '0 && min_cnt == '0)); // R1

endmodule

// File: tb/sim_balance_gate_ctrl.sv
`timescale 1ns/100ps
module sim_balance_gate_ctrl;

  localparam logic [7:0] A_CTRL = 8'h32;
  localparam logic [7:0] A_TIME = 8'h33;
  localparam int TPM = 60;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_we = 1'b0;
  logic [7:0] reg_addr = 8'h00;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       sec_tick = 1'b0;
  logic [5:0] bal_en;

  int checks = 0;
  int errors = 0;

  // Reference state: pattern, limit, flag, counted ticks since restart
  logic [5:0] m_ctrl = '0;
  logic [5:0] m_lim = '0;
  logic       m_stk = 1'b0;
  int         m_el = 0;

  always #2.5 clk = ~clk;

  balance_gate_ctrl u0 (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sec_tick(sec_tick),
    .bal_en(bal_en)
  );

  function automatic logic [5:0] exp_out();
    return (m_lim != 0) ? m_ctrl : 6'h00;
  endfunction

  function automatic logic exp_pending();
    return (exp_out() != 0) && (m_el >= TPM * int'(m_lim));
  endfunction

  task automatic chk(input string tag, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, expv, $time);
    end
  endtask

  task automatic model(input bit we, input logic [7:0] a, input logic [7:0] d, input bit tk);
    bit act, pend, cw, tw;
    act  = exp_out() != 0;
    pend = exp_pending();
    cw   = we && a == A_CTRL;
    tw   = we && a == A_TIME;
    if (cw && d[5:0] != 0) m_el = 0;
    else if (act && !pend && tk) m_el = m_el + 1;
    if (cw) m_ctrl = d[5:0];
    else if (pend) m_ctrl = '0;
    if (pend && !cw) m_stk = 1'b1;
    else if (tw && d[7]) m_stk = 1'b0;
    if (tw) m_lim = d[5:0];
  endtask

  task automatic compare_all();
    logic [5:0] eo;
    eo = exp_out();
    chk("R2", bal_en, eo);
    reg_addr = A_CTRL; #1;
    chk("R8", reg_rdata, {2'b00, eo});
    reg_addr = A_TIME; #1;
    chk("R6", reg_rdata[7], m_stk);
    chk("R7", reg_rdata[6], eo != 0);
    chk("R8", reg_rdata[5:0], m_lim);
  endtask

  task automatic step(input bit we, input logic [7:0] a, input logic [7:0] d, input bit tk);
    reg_we = we; reg_addr = a; reg_wdata = d; sec_tick = tk;
    @(posedge clk);
    model(we, a, d, tk);
    @(negedge clk);
    reg_we = 1'b0; sec_tick = 1'b0;
    compare_all();
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    step(1'b1, a, d, 1'b0);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 8'h00, 8'h00, 1'b1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk("R1", bal_en, 0);
    reg_addr = A_CTRL; #1; chk("R1", reg_rdata, 0);
    reg_addr = A_TIME; #1; chk("R1", reg_rdata, 0);
    reg_addr = 8'h40;  #1; chk("R8", reg_rdata, 0);

    // R3: limit zero keeps outputs off, pattern retained
    wr(A_CTRL, 8'h2A);
    chk("R3", bal_en, 0);
    ticks(100);                        // R11: no counting while inactive
    wr(A_TIME, 8'h01);
    chk("R3", bal_en, 6'h2A);
    ticks(59);
    chk("R11", bal_en, 6'h2A);
    ticks(1);
    chk("R5", bal_en, 6'h2A);          // still on one cycle after last tick
    step(1'b0, 8'h00, 8'h00, 1'b0);
    chk("R5", bal_en, 0);
    reg_addr = A_TIME; #1; chk("R6", reg_rdata[7], 1);

    // R6: clear flag
    wr(A_TIME, 8'h82);
    reg_addr = A_TIME; #1; chk("R6", reg_rdata, 8'h02);

    // R4: nonzero write restarts elapsed time; zero write turns off
    wr(A_CTRL, 8'h15);
    ticks(50);
    wr(A_CTRL, 8'h15);
    ticks(100);
    step(1'b0, 8'h00, 8'h00, 1'b0);
    chk("R4", bal_en, 6'h15);
    wr(A_CTRL, 8'h00);
    chk("R4", bal_en, 0);

    // R9: lowering limit below elapsed time
    wr(A_TIME, 8'h03);
    wr(A_CTRL, 8'h3F);
    ticks(130);
    wr(A_TIME, 8'h02);
    chk("R9", bal_en, 6'h3F);
    step(1'b0, 8'h00, 8'h00, 1'b0);
    chk("R9", bal_en, 0);

    // R10: control write wins over pending timeout
    wr(A_TIME, 8'h81);
    wr(A_CTRL, 8'h07);
    ticks(60);
    wr(A_CTRL, 8'h38);
    chk("R10", bal_en, 6'h38);
    reg_addr = A_TIME; #1;
    chk("R10", reg_rdata[7], 0);
    chk("R7", reg_rdata[6], 1);

    // R5: maximum limit of 63 minutes
    wr(A_TIME, 8'h3F);
    wr(A_CTRL, 8'h01);
    ticks(63 * TPM - 1);
    step(1'b0, 8'h00, 8'h00, 1'b0);
    chk("R5", bal_en, 6'h01);
    ticks(1);
    step(1'b0, 8'h00, 8'h00, 1'b0);
    chk("R5", bal_en, 0);

    // Random phase against the reference model
    void'($urandom(32'h5EED_0042));
    for (int n = 0; n < 5000; n++) begin
      int r;
      r = int'($urandom_range(0, 199));
      if (r < 2)       wr(A_CTRL, 8'($urandom()));
      else if (r < 3)  wr(A_TIME, {1'($urandom()), 1'b0, 6'($urandom_range(0, 3))});
      else if (r < 4)  wr(8'($urandom_range(0, 255)), 8'($urandom()));
      else if (r < 5)  wr(A_CTRL, 8'h00);
      else             step(1'b0, 8'h00, 8'h00, 1'($urandom_range(0, 9) < 8));
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule